// File: doc/BRIEF.md
# Staged Configuration Write Bridge

This block is the bus-side write path into a slow-running timekeeping core. Software opens a configuration session by setting an enable bit, writes any of the 16-bit halves of three 32-bit values (reload, counter, alarm) into staging registers, and closes the session by clearing the enable bit. Closing the session hands the staged halves to the slow clock domain, where each written half appears as a single-cycle load strobe together with its data.

While a hand-over is in flight, a write-done status bit reads 0 and every register write is dropped, including writes to the control and interrupt-enable registers. The request crosses to the slow domain as a toggle through a two-flop synchronizer. The slow side holds for a fixed number of its own cycles before it toggles an acknowledge back, which is synchronized the same way. Only halves written in the current session are loaded; the other halves keep their previous values on the core side.

Top module: `cfg_write_bridge`

## Requirements
- R1: After reset, `wr_done` is 1, `cfg_mode` is 0, `irq_enable` is 0 and no `core_load` bit is set.
- R2: The register map is address 0 control (bit 0 is the configuration enable) and address 1 interrupt enable (low 3 bits). Addresses 2 to 7 hold the halves in the order reload low, reload high, counter low, counter high, alarm low, alarm high. Half k sits at address 2+k, drives `core_load[k]`, and drives `core_value[16k+15:16k]`. A half write made while `cfg_mode` is 0 is dropped.
- R3: Half writes made during a session produce no load strobe and leave `wr_done` at 1 until the session is closed.
- R4: When a write clears the enable bit and at least one half was written in the session, `wr_done` reads 0 in the bus cycle right after that write.
- R5: Closing a session strobes exactly the halves written in it, and each of those strobes carries the last value written to that half.
- R6: `wr_done` stays 0 for at least 3 slow-clock cycles per commit.
- R7: While `wr_done` is 0, writes to every address, including control and interrupt enable, have no effect.
- R8: Closing a session in which no half was written starts no transfer, and `wr_done` stays 1.
- R9: Every load strobe lasts exactly one slow-clock cycle, and each written half is strobed once per commit.
- R10: A write to the interrupt-enable register while `wr_done` is 1 shows up on `irq_enable` on the next bus cycle.
- R11: A half that is not strobed keeps its previous `core_value` slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cfg_mode | output | 1 | Configuration enable bit |
| wr_done | output | 1 | 1 when idle, 0 while a commit is in flight |
| irq_enable | output | 3 | Interrupt-enable register |
| core_clk | input | 1 | Slow core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_load | output | 6 | One-cycle load strobe per half |
| core_value | output | 96 | Loaded half values, half k at bits 16k+15:16k |

## Verification
The assertions take for granted that the slow clock runs well below a quarter of the bus clock. They also assume the staged halves and the written-half mask hold still from the request toggle until the acknowledge returns, which is what lets the core sample them without a synchronizer. The stimulus runs the core clock at one tenth of the bus rate and drives every write half a bus cycle away from the edge. It only releases the resets after both clocks have run for several cycles, so the toggles start from a known state in both domains.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int unsigned CWB_HALF_W   = 16;
    localparam int unsigned CWB_NUM_VALS = 3;
    localparam int unsigned CWB_IRQ_W    = 3;
    localparam int unsigned CWB_HOLD_CYC = 3;
    localparam int unsigned CWB_SYNC_N   = 2;
    localparam int unsigned CWB_ADDR_CTRL = 0;
    localparam int unsigned CWB_ADDR_IRQ  = 1;
    localparam int unsigned CWB_ADDR_HALF = 2;

    typedef enum logic [0:0] {
        CORE_IDLE = 1'b0,
        CORE_HOLD = 1'b1
    } core_state_e;

    function automatic int unsigned half_addr(input int unsigned k);
        return CWB_ADDR_HALF + k;
    endfunction
endpackage

// File: rtl/cwb_sync.sv
module cwb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cwb_bus_regs.sv
module cwb_bus_regs
    import cwb_pkg::*;
#(
    parameter int unsigned HALF_W = CWB_HALF_W,
    parameter int unsigned NHALF  = 2*CWB_NUM_VALS,
    parameter int unsigned IRQ_W  = CWB_IRQ_W,
    parameter int unsigned SYNC_N = CWB_SYNC_N,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [HALF_W-1:0]       wr_data,
    input  logic                    ack_tgl_async,
    output logic                    cfg_q,
    output logic                    ready_q,
    output logic [IRQ_W-1:0]        irq_q,
    output logic                    req_tgl,
    output logic [NHALF-1:0]        dirty_q,
    output logic [NHALF*HALF_W-1:0] stage_flat
);
    logic [HALF_W-1:0] stage_q [NHALF];
    logic [NHALF-1:0]  half_hit;
    logic              wr_ok, ctrl_hit, irq_hit, cfg_exit, commit;
    logic              ack_s, ack_d, ack_edge;

    assign wr_ok    = wr_en && ready_q;
    assign ctrl_hit = (wr_addr == ADDR_W'(CWB_ADDR_CTRL));
    assign irq_hit  = (wr_addr == ADDR_W'(CWB_ADDR_IRQ));
    assign cfg_exit = wr_ok && ctrl_hit && cfg_q && !wr_data[0];
    assign commit   = cfg_exit && (dirty_q != '0);

    for (genvar k = 0; k < NHALF; k++) begin : g_half
        assign half_hit[k] = wr_ok && cfg_q && (wr_addr == ADDR_W'(half_addr(k)));
        assign stage_flat[k*HALF_W +: HALF_W] = stage_q[k];
    end

    cwb_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_async),
        .q   (ack_s)
    );

    assign ack_edge = ack_s ^ ack_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= 1'b0;
            ready_q <= 1'b1;
            irq_q   <= '0;
            req_tgl <= 1'b0;
            ack_d   <= 1'b0;
            dirty_q <= '0;
            for (int k = 0; k < NHALF; k++) stage_q[k] <= '0;
        end else begin
            ack_d <= ack_s;
            if (wr_ok && ctrl_hit) cfg_q <= wr_data[0];
            if (wr_ok && irq_hit)  irq_q <= wr_data[IRQ_W-1:0];
            for (int k = 0; k < NHALF; k++) begin
                if (half_hit[k]) begin
                    stage_q[k] <= wr_data;
                    dirty_q[k] <= 1'b1;
                end
            end
            if (commit) begin
                req_tgl <= ~req_tgl;
                ready_q <= 1'b0;
            end
            if (ack_edge) begin
                ready_q <= 1'b1;
                dirty_q <= '0;
            end
        end
    end

    // R4: a session close with written halves drops the status bit
    a_r4_drop_on_close: assert property (@(posedge clk) disable iff (rst)
        commit |=> !ready_q);
    // R7: staging and interrupt enable frozen while busy
    a_r7_stage_frozen: assert property (@(posedge clk) disable iff (rst)
        !ready_q |=> $stable(stage_flat) && $stable(irq_q) && $stable(cfg_q));
    // R8: a transfer only ever starts with something staged
    a_r8_no_empty_commit: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_q) |-> (dirty_q != '0));
    // R3: the request toggle only moves on a session close
    a_r3_req_only_on_close: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(req_tgl));
endmodule

// File: rtl/cwb_core_load.sv
module cwb_core_load
    import cwb_pkg::*;
#(
    parameter int unsigned HALF_W   = CWB_HALF_W,
    parameter int unsigned NHALF    = 2*CWB_NUM_VALS,
    parameter int unsigned HOLD_CYC = CWB_HOLD_CYC,
    parameter int unsigned SYNC_N   = CWB_SYNC_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_tgl_async,
    input  logic [NHALF-1:0]        dirty_async,
    input  logic [NHALF*HALF_W-1:0] stage_async,
    output logic [NHALF-1:0]        load_q,
    output logic [NHALF*HALF_W-1:0] value_q,
    output logic                    ack_tgl
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

    core_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             req_s, req_d, req_edge, hold_last;

    cwb_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl_async),
        .q   (req_s)
    );

    assign req_edge  = req_s ^ req_d;
    assign hold_last = (state_q == CORE_HOLD) && (cnt_q == CNT_W'(HOLD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CORE_IDLE;
            cnt_q   <= '0;
            req_d   <= 1'b0;
            ack_tgl <= 1'b0;
            load_q  <= '0;
            value_q <= '0;
        end else begin
            req_d  <= req_s;
            load_q <= '0;
            case (state_q)
                CORE_IDLE: begin
                    if (req_edge) begin
                        load_q  <= dirty_async;
                        for (int k = 0; k < NHALF; k++) begin
                            if (dirty_async[k])
                                value_q[k*HALF_W +: HALF_W] <= stage_async[k*HALF_W +: HALF_W];
                        end
                        cnt_q   <= '0;
                        state_q <= CORE_HOLD;
                    end
                end
                default: begin
                    if (hold_last) begin
                        ack_tgl <= ~ack_tgl;
                        state_q <= CORE_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R9: strobes are single-cycle pulses
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (load_q != '0) |=> (load_q == '0));
    // R9: a new request never lands on a hand-over in progress
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        req_edge |-> (state_q == CORE_IDLE));
    // R5: only staged halves are strobed
    a_r5_only_dirty: assert property (@(posedge clk) disable iff (rst)
        (load_q & ~dirty_async) == '0);
    // R6: acknowledge waits for the full hold window
    a_r6_hold_window: assert property (@(posedge clk) disable iff (rst)
        !hold_last |=> $stable(ack_tgl));
    // R11: unstrobed slices keep their value
    a_r11_keep_value: assert property (@(posedge clk) disable iff (rst)
        (load_q == '0) |-> $stable(value_q));
endmodule

// File: rtl/cfg_write_bridge.sv
module cfg_write_bridge
    import cwb_pkg::*;
#(
    parameter int unsigned HALF_W   = CWB_HALF_W,
    parameter int unsigned NUM_VALS = CWB_NUM_VALS,
    parameter int unsigned IRQ_W    = CWB_IRQ_W,
    parameter int unsigned HOLD_CYC = CWB_HOLD_CYC,
    parameter int unsigned SYNC_N   = CWB_SYNC_N,
    localparam int unsigned NHALF   = 2*NUM_VALS,
    localparam int unsigned ADDR_W  = $clog2(CWB_ADDR_HALF + NHALF)
) (
    input  logic                    bus_clk,
    input  logic                    bus_rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [HALF_W-1:0]       wr_data,
    output logic                    cfg_mode,
    output logic                    wr_done,
    output logic [IRQ_W-1:0]        irq_enable,
    input  logic                    core_clk,
    input  logic                    core_rst,
    output logic [NHALF-1:0]        core_load,
    output logic [NHALF*HALF_W-1:0] core_value
);
    logic                    req_tgl, ack_tgl;
    logic [NHALF-1:0]        dirty;
    logic [NHALF*HALF_W-1:0] stage_flat;

    cwb_bus_regs #(
        .HALF_W (HALF_W),
        .NHALF  (NHALF),
        .IRQ_W  (IRQ_W),
        .SYNC_N (SYNC_N),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk           (bus_clk),
        .rst           (bus_rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .ack_tgl_async (ack_tgl),
        .cfg_q         (cfg_mode),
        .ready_q       (wr_done),
        .irq_q         (irq_enable),
        .req_tgl       (req_tgl),
        .dirty_q       (dirty),
        .stage_flat    (stage_flat)
    );

    cwb_core_load #(
        .HALF_W   (HALF_W),
        .NHALF    (NHALF),
        .HOLD_CYC (HOLD_CYC),
        .SYNC_N   (SYNC_N)
    ) u_core (
        .clk           (core_clk),
        .rst           (core_rst),
        .req_tgl_async (req_tgl),
        .dirty_async   (dirty),
        .stage_async   (stage_flat),
        .load_q        (core_load),
        .value_q       (core_value),
        .ack_tgl       (ack_tgl)
    );
endmodule

// File: tb/tb_cfg_write_bridge.sv
`timescale 1ns/1ps
module tb_cfg_write_bridge;
    localparam int NH = 6;

    logic        bus_clk = 0, core_clk = 0, bus_rst = 1, core_rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cfg_mode, wr_done;
    logic [2:0]  irq_enable;
    logic [NH-1:0]    core_load;
    logic [NH*16-1:0] core_value;

    int n_run = 0, n_fail = 0;
    int ld_cnt [NH];
    logic [15:0] ld_val [NH];
    int wide_err = 0, busy_cc = 0;
    logic [NH-1:0] prev_ld = '0;
    bit done = 0;

    always #2  bus_clk  = ~bus_clk;
    always #20 core_clk = ~core_clk;

    cfg_write_bridge dut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_mode(cfg_mode), .wr_done(wr_done),
        .irq_enable(irq_enable), .core_clk(core_clk), .core_rst(core_rst),
        .core_load(core_load), .core_value(core_value)
    );

    initial for (int k = 0; k < NH; k++) begin ld_cnt[k] = 0; ld_val[k] = '0; end

    always @(posedge core_clk) begin
        if (!core_rst) begin
            for (int k = 0; k < NH; k++) begin
                if (core_load[k]) begin
                    ld_cnt[k] = ld_cnt[k] + 1;
                    ld_val[k] = core_value[k*16 +: 16];
                    if (prev_ld[k]) wide_err = wide_err + 1;
                end
            end
            prev_ld = core_load;
            if (!wr_done) busy_cc = busy_cc + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && !wr_done; i++) @(negedge bus_clk);
    endtask

    task automatic snap(output int c [NH], output int b);
        for (int k = 0; k < NH; k++) c[k] = ld_cnt[k];
        b = busy_cc;
    endtask

    task automatic t_reset();
        check("R1 done", wr_done, 1);
        check("R1 cfg", cfg_mode, 0);
        check("R1 irq", irq_enable, 0);
        check("R1 load", core_load, 0);
    endtask

    task automatic t_irq();
        bus_wr(3'd1, 16'h0005);
        check("R10 irq write", irq_enable, 3'd5);
    endtask

    task automatic t_outside_and_empty();
        int c0 [NH]; int b0;
        snap(c0, b0);
        bus_wr(3'd4, 16'hDEAD);
        bus_wr(3'd0, 16'h0001);
        check("R2 cfg set", cfg_mode, 1);
        bus_wr(3'd0, 16'h0000);
        check("R8 done stays high", wr_done, 1);
        repeat (200) @(negedge bus_clk);
        check("R8 done still high", wr_done, 1);
        check("R2 no strobe from write outside session", ld_cnt[2] - c0[2], 0);
    endtask

    task automatic t_partial();
        int c0 [NH]; int b0;
        snap(c0, b0);
        bus_wr(3'd0, 16'h0001);
        bus_wr(3'd2, 16'h1111);
        bus_wr(3'd5, 16'h2222);
        bus_wr(3'd5, 16'h3333);
        repeat (200) @(negedge bus_clk);
        check("R3 no strobe in session", ld_cnt[0] - c0[0], 0);
        check("R3 done high in session", wr_done, 1);
        bus_wr(3'd0, 16'h0000);
        check("R4 done low after close", wr_done, 0);
        bus_wr(3'd1, 16'h0002);
        bus_wr(3'd0, 16'h0001);
        bus_wr(3'd3, 16'h7777);
        check("R7 irq unchanged while busy", irq_enable, 3'd5);
        check("R7 cfg unchanged while busy", cfg_mode, 0);
        wait_idle();
        check("R6 done returns", wr_done, 1);
        check("R6 busy core cycles >= 3", (busy_cc - b0) >= 3, 1);
        check("R5 half0 strobed once", ld_cnt[0] - c0[0], 1);
        check("R5 half3 strobed once", ld_cnt[3] - c0[3], 1);
        check("R5 half1 not strobed", ld_cnt[1] - c0[1], 0);
        check("R5 half0 data", ld_val[0], 16'h1111);
        check("R5 last write wins half3", ld_val[3], 16'h3333);
        check("R11 half1 slice kept", core_value[16 +: 16], 16'h0000);
        check("R7 cfg after busy", cfg_mode, 0);
        check("R9 pulse width", wide_err, 0);
    endtask

    task automatic t_all();
        int c0 [NH]; int b0;
        snap(c0, b0);
        bus_wr(3'd0, 16'h0001);
        for (int k = 0; k < NH; k++) bus_wr(3'(2 + k), 16'hA000 + 16'(k));
        bus_wr(3'd0, 16'h0000);
        check("R4 done low full commit", wr_done, 0);
        wait_idle();
        for (int k = 0; k < NH; k++) begin
            check("R9 each half once", ld_cnt[k] - c0[k], 1);
            check("R5 value", core_value[k*16 +: 16], 16'hA000 + 16'(k));
        end
        check("R9 pulse width all", wide_err, 0);
        check("R6 busy window", (busy_cc - b0) >= 3, 1);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge core_clk);
        @(negedge bus_clk);
        bus_rst = 0; core_rst = 0;
        @(negedge bus_clk);
        t_reset();
        t_irq();
        t_outside_and_empty();
        t_partial();
        t_all();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule